// File: doc/BRIEF.md
# Exception Priority Resolver

This block keeps the per-exception state of a vectored interrupt controller and decides, every cycle, which exception should be taken next. Each slot has an enable bit, a pending bit, an active bit and a priority. Sixteen slots are internal, and a parameterised number of external lines follow them. A parallel compare tree picks the most urgent enabled and pending exception. A second tree finds the most urgent active handler. The block combines these with the CPU mask inputs to produce the preemption request, the execution priority and a take-permission flag.

State is changed through a one-cycle command port that names a slot and an operation. Priorities are signed 10-bit values. This lets the three fixed slots (-3, -2, -1), the configurable 8-bit range and the idle sentinel 0x100 all compare in a single domain. All results are registered.

Top module: `exc_prio_resolver`

## Requirements
- R1: After reset no slot is enabled, pending or active. The outputs read: pending vector 0, pending priority 0x100, active priority 0x100, execution priority 0x100, preemption 0, take 0, one-active 1 and external-pending 0.
- R2: The pending vector is the enabled and pending slot with the numerically lowest priority. On a tie, the lowest slot number wins. The pending priority output is that slot's priority, unmasked.
- R3: A pending slot that is not enabled is never selected. With no candidate, the pending vector is 0 and the pending priority is 0x100.
- R4: Slots 1, 2 and 3 have fixed priorities of -3, -2 and -1, and priority commands to them are ignored. Every command to slot 0, or to a slot number at or above 16+NUM_EXT, is ignored.
- R5: The active priority is the lowest priority among active slots, ANDed with all-ones shifted left by (group_i + 1). It is 0x100 when no slot is active.
- R6: preempt_o is 1 exactly when the pending priority is below the masked active priority. faultmask_i, intmask_i and basepri_i have no effect on it.
- R7: The base execution priority is selected in this order. It is -1 when faultmask_i is set, else 0 when intmask_i is set, else basepri_i ANDed with the group mask when basepri_i is nonzero, else 0x100. exec_prio_o is the minimum of this base value and the active priority.
- R8: can_take_o is 1 exactly when exec_prio_o is greater than the pending priority.
- R9: one_active_o is 1 when zero or one slot is active, and 0 when two or more slots are active.
- R10: ext_pend_o is 1 when any slot numbered 16 or above is pending, whether or not that slot is enabled.
- R11: Every output is registered. It reflects the state and inputs present at the previous clock edge, so a command shows at the outputs one cycle after it updates the state.
- R12: A command is accepted when cmd_valid_i is 1 and is selected by cmd_kind_i:
  - 0: set enable
  - 1: clear enable
  - 2: set pending
  - 3: clear pending
  - 4: set active
  - 5: clear active
  - 6: write priority from cmd_prio_i
  - 7: no operation

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_kind_i | input | 3 | Command operation |
| cmd_idx_i | input | IDX_W | Target exception slot |
| cmd_prio_i | input | 8 | Priority for a write-priority command |
| group_i | input | 3 | Priority grouping field |
| faultmask_i | input | 1 | Fault mask |
| intmask_i | input | 1 | Interrupt mask |
| basepri_i | input | 8 | Base priority threshold |
| pend_vec_o | output | IDX_W | Selected pending exception |
| pend_prio_o | output | 10 | Priority of the selected exception, signed |
| act_prio_o | output | 10 | Group-masked active priority, signed |
| exec_prio_o | output | 10 | Execution priority, signed |
| preempt_o | output | 1 | Preemption request |
| can_take_o | output | 1 | Pending exception may be taken |
| one_active_o | output | 1 | At most one handler active |
| ext_pend_o | output | 1 | Some external slot is pending |

## Verification
The hardest situations to reach are those where a masked or fixed value meets another value at equal magnitude. In these cases a strict comparison must refuse, for example:
- the active fixed -1 slot masked down to -2 while the -2 slot is pending;
- a group setting that wipes an active priority to 0 so that preemption falls away.

The stimulus reaches them with a fixed sequence of commands that pends and activates the fixed slots after configurable slots are already set up. It then sweeps the group field and the CPU mask inputs while the slot state is held. Each step's full output set is compared against values worked out from the requirements.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;
  localparam int PRIO_W   = 10;
  localparam int NUM_SYS  = 16;

  typedef logic signed [PRIO_W-1:0] prio_t;

  localparam prio_t PRIO_NONE = 10'sh100;

  typedef enum logic [2:0] {
    CMD_EN_SET   = 3'd0,
    CMD_EN_CLR   = 3'd1,
    CMD_PEND_SET = 3'd2,
    CMD_PEND_CLR = 3'd3,
    CMD_ACT_SET  = 3'd4,
    CMD_ACT_CLR  = 3'd5,
    CMD_PRIO     = 3'd6,
    CMD_NOP      = 3'd7
  } cmd_kind_e;

  // keeps only the group-priority bits
  function automatic prio_t grp_mask(input logic [2:0] g);
    logic [3:0] sh;
    sh = {1'b0, g} + 4'd1;
    return prio_t'(10'h3FF << sh);
  endfunction

  // fixed priorities of slots 1..3 are -3, -2, -1
  function automatic prio_t fixed_prio(input int slot);
    return prio_t'(slot - 4);
  endfunction

  // flip sign bit so signed order becomes unsigned order
  function automatic logic [PRIO_W-1:0] to_key(input prio_t p);
    return {~p[PRIO_W-1], p[PRIO_W-2:0]};
  endfunction

  function automatic prio_t from_key(input logic [PRIO_W-1:0] k);
    return prio_t'({~k[PRIO_W-1], k[PRIO_W-2:0]});
  endfunction
endpackage

// File: rtl/exc_state.sv
module exc_state
  import exc_prio_pkg::*;
#(
  parameter int NUM_EXC = 48,
  parameter int IDX_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_kind_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [7:0]       cmd_prio_i,
  output logic [NUM_EXC-1:0] en_o,
  output logic [NUM_EXC-1:0] pend_o,
  output logic [NUM_EXC-1:0] act_o,
  output prio_t            prio_o [NUM_EXC]
);
  cmd_kind_e kind;
  assign kind = cmd_kind_e'(cmd_kind_i);

  assign en_o[0]   = 1'b0;
  assign pend_o[0] = 1'b0;
  assign act_o[0]  = 1'b0;
  assign prio_o[0] = PRIO_NONE;

  for (genvar s = 1; s < NUM_EXC; s++) begin : g_slot
    logic hit, en_q, pend_q, act_q;
    assign hit = cmd_valid_i && (cmd_idx_i == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        pend_q <= 1'b0;
        act_q  <= 1'b0;
      end else if (hit) begin
        case (kind)
          CMD_EN_SET:   en_q   <= 1'b1;
          CMD_EN_CLR:   en_q   <= 1'b0;
          CMD_PEND_SET: pend_q <= 1'b1;
          CMD_PEND_CLR: pend_q <= 1'b0;
          CMD_ACT_SET:  act_q  <= 1'b1;
          CMD_ACT_CLR:  act_q  <= 1'b0;
          default: ;
        endcase
      end
    end

    assign en_o[s]   = en_q;
    assign pend_o[s] = pend_q;
    assign act_o[s]  = act_q;

    if (s < 4) begin : g_fixed
      assign prio_o[s] = fixed_prio(s);
    end else begin : g_cfg
      logic [7:0] prio_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          prio_q <= 8'h00;
        else if (hit && kind == CMD_PRIO)     prio_q <= cmd_prio_i;
      end
      assign prio_o[s] = prio_t'({2'b00, prio_q});
    end
  end
endmodule

// File: rtl/min_tree.sv
module min_tree #(
  parameter int N = 48,
  parameter int W = 16
) (
  input  logic [N-1:0] valid_i,
  input  logic [W-1:0] key_i [N],
  output logic         any_o,
  output logic [W-1:0] key_o
);
  localparam int LVL = (N > 1) ? $clog2(N) : 1;
  localparam int P   = 1 << LVL;

  logic         nv [1:2*P-1];
  logic [W-1:0] nk [1:2*P-1];

  for (genvar k = 0; k < P; k++) begin : g_leaf
    if (k < N) begin : g_real
      assign nv[P+k] = valid_i[k];
      assign nk[P+k] = key_i[k];
    end else begin : g_pad
      assign nv[P+k] = 1'b0;
      assign nk[P+k] = '0;
    end
  end

  // left child holds lower slot numbers; it wins ties
  for (genvar i = 1; i < P; i++) begin : g_node
    logic pick_r;
    assign pick_r = nv[2*i+1] && (!nv[2*i] || (nk[2*i+1] < nk[2*i]));
    assign nv[i]  = nv[2*i] | nv[2*i+1];
    assign nk[i]  = pick_r ? nk[2*i+1] : nk[2*i];
  end

  assign any_o = nv[1];
  assign key_o = nk[1];
endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
  import exc_prio_pkg::*;
#(
  parameter int NUM_EXT = 32,
  localparam int NUM_EXC = NUM_SYS + NUM_EXT,
  localparam int IDX_W   = $clog2(NUM_EXC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_kind_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [7:0]       cmd_prio_i,
  input  logic [2:0]       group_i,
  input  logic             faultmask_i,
  input  logic             intmask_i,
  input  logic [7:0]       basepri_i,
  output logic [IDX_W-1:0] pend_vec_o,
  output logic signed [PRIO_W-1:0] pend_prio_o,
  output logic signed [PRIO_W-1:0] act_prio_o,
  output logic signed [PRIO_W-1:0] exec_prio_o,
  output logic             preempt_o,
  output logic             can_take_o,
  output logic             one_active_o,
  output logic             ext_pend_o
);
  localparam int PKW = PRIO_W + IDX_W;

  logic [NUM_EXC-1:0] en, pend, act, cand;
  prio_t              prio [NUM_EXC];

  exc_state #(.NUM_EXC(NUM_EXC), .IDX_W(IDX_W)) u_state (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_kind_i, .cmd_idx_i, .cmd_prio_i,
    .en_o(en), .pend_o(pend), .act_o(act), .prio_o(prio)
  );

  logic [PKW-1:0]    pkey [NUM_EXC];
  logic [PRIO_W-1:0] akey [NUM_EXC];

  for (genvar s = 0; s < NUM_EXC; s++) begin : g_key
    assign pkey[s] = {to_key(prio[s]), IDX_W'(s)};
    assign akey[s] = to_key(prio[s]);
  end

  assign cand = en & pend;

  logic              p_any, a_any;
  logic [PKW-1:0]    p_best;
  logic [PRIO_W-1:0] a_best;

  min_tree #(.N(NUM_EXC), .W(PKW)) u_pend_tree (
    .valid_i(cand), .key_i(pkey), .any_o(p_any), .key_o(p_best)
  );

  min_tree #(.N(NUM_EXC), .W(PRIO_W)) u_act_tree (
    .valid_i(act), .key_i(akey), .any_o(a_any), .key_o(a_best)
  );

  prio_t            pend_prio_d, act_prio_d, base_d, exec_d, gmask;
  logic [IDX_W-1:0] pend_vec_d;

  always_comb begin
    gmask       = grp_mask(group_i);
    pend_vec_d  = p_any ? p_best[IDX_W-1:0] : '0;
    pend_prio_d = p_any ? from_key(p_best[PKW-1:IDX_W]) : PRIO_NONE;
    act_prio_d  = a_any ? (from_key(a_best) & gmask) : PRIO_NONE;
    if (faultmask_i)           base_d = -10'sd1;
    else if (intmask_i)        base_d = 10'sd0;
    else if (basepri_i != '0)  base_d = prio_t'({2'b00, basepri_i}) & gmask;
    else                       base_d = PRIO_NONE;
    exec_d = (base_d < act_prio_d) ? base_d : act_prio_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vec_o   <= '0;
      pend_prio_o  <= PRIO_NONE;
      act_prio_o   <= PRIO_NONE;
      exec_prio_o  <= PRIO_NONE;
      preempt_o    <= 1'b0;
      can_take_o   <= 1'b0;
      one_active_o <= 1'b1;
      ext_pend_o   <= 1'b0;
    end else begin
      pend_vec_o   <= pend_vec_d;
      pend_prio_o  <= pend_prio_d;
      act_prio_o   <= act_prio_d;
      exec_prio_o  <= exec_d;
      preempt_o    <= pend_prio_d < act_prio_d;
      can_take_o   <= exec_d > pend_prio_d;
      one_active_o <= $countones(act) <= 1;
      ext_pend_o   <= |pend[NUM_EXC-1:NUM_SYS];
    end
  end
endmodule

// File: rtl/exc_prio_resolver_chk.sv
module exc_prio_resolver_chk
  import exc_prio_pkg::*;
#(
  parameter int NUM_EXT = 32,
  localparam int IDX_W  = $clog2(NUM_SYS + NUM_EXT)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             faultmask_i,
  input logic [IDX_W-1:0] pend_vec_o,
  input logic signed [PRIO_W-1:0] pend_prio_o,
  input logic signed [PRIO_W-1:0] act_prio_o,
  input logic signed [PRIO_W-1:0] exec_prio_o,
  input logic             preempt_o,
  input logic             can_take_o,
  input logic             one_active_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_none_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vec_o == '0) |-> (pend_prio_o == PRIO_NONE));

  p_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vec_o == IDX_W'(2)) |-> (pend_prio_o == -10'sd2));

  p_preempt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preempt_o |-> (pend_prio_o < act_prio_o));

  p_no_preempt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preempt_o |-> (pend_prio_o >= act_prio_o));

  p_exec_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_prio_o <= act_prio_o);

  p_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(faultmask_i)) |-> (exec_prio_o <= -10'sd1));

  p_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    can_take_o |-> (exec_prio_o > pend_prio_o));

  p_no_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !can_take_o |-> (exec_prio_o <= pend_prio_o));

  p_idle_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_prio_o == PRIO_NONE) |-> one_active_o);
endmodule

bind exc_prio_resolver exc_prio_resolver_chk #(.NUM_EXT(NUM_EXT)) u_chk (.*);

// File: tb/tb_exc_prio_resolver.sv
module tb_exc_prio_resolver;
  localparam int NUM_EXT = 32;
  localparam int IDX_W   = $clog2(16 + NUM_EXT);
  localparam logic [9:0] NONE = 10'h100;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_kind = '0;
  logic [IDX_W-1:0] cmd_idx = '0;
  logic [7:0] cmd_prio = '0;
  logic [2:0] group = '0;
  logic fm = 1'b0, im = 1'b0;
  logic [7:0] bp = '0;
  logic [IDX_W-1:0] pend_vec;
  logic signed [9:0] pend_prio, act_prio, exec_prio;
  logic preempt, can_take, one_active, ext_pend;

  always #10 clk = ~clk;

  exc_prio_resolver #(.NUM_EXT(NUM_EXT)) dut (
    .clk_i(clk), .rst_ni, .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind),
    .cmd_idx_i(cmd_idx), .cmd_prio_i(cmd_prio), .group_i(group),
    .faultmask_i(fm), .intmask_i(im), .basepri_i(bp),
    .pend_vec_o(pend_vec), .pend_prio_o(pend_prio), .act_prio_o(act_prio),
    .exec_prio_o(exec_prio), .preempt_o(preempt), .can_take_o(can_take),
    .one_active_o(one_active), .ext_pend_o(ext_pend)
  );

  typedef struct {
    string tag;
    logic [IDX_W-1:0] vec;
    logic [9:0] pp, ap, ep;
    logic pre, take, one, ext;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // monitor: pops each expectation as soon as it is posted
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      checks++;
      if (pend_vec !== e.vec || pend_prio !== e.pp || act_prio !== e.ap ||
          exec_prio !== e.ep || preempt !== e.pre || can_take !== e.take ||
          one_active !== e.one || ext_pend !== e.ext) begin
        errors++;
        $display("FAIL %s actual vec=%0d pp=%h ap=%h ep=%h pre=%b take=%b one=%b ext=%b expected vec=%0d pp=%h ap=%h ep=%h pre=%b take=%b one=%b ext=%b",
          e.tag, pend_vec, pend_prio, act_prio, exec_prio, preempt, can_take,
          one_active, ext_pend, e.vec, e.pp, e.ap, e.ep, e.pre, e.take,
          e.one, e.ext);
      end
    end
  end

  task automatic cmd(input int kind, input int idx, input int pr = 0);
    cmd_valid = 1'b1;
    cmd_kind  = 3'(kind);
    cmd_idx   = IDX_W'(idx);
    cmd_prio  = 8'(pr);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input bit wait_edge,
                            input int vec, input logic [9:0] pp, ap, ep,
                            input logic pre, take, one, ext);
    exp_t e;
    if (wait_edge) @(negedge clk);
    e.tag = tag; e.vec = IDX_W'(vec); e.pp = pp; e.ap = ap; e.ep = ep;
    e.pre = pre; e.take = take; e.one = one; e.ext = ext;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    expect_out("R1 reset", 1, 0, NONE, NONE, NONE, 0, 0, 1, 0);

    cmd(2, 36);
    expect_out("R3 R10 disabled pending", 1, 0, NONE, NONE, NONE, 0, 0, 1, 1);

    cmd(0, 36);
    expect_out("R11 one-cycle latency", 0, 0, NONE, NONE, NONE, 0, 0, 1, 1);
    expect_out("R2 single candidate", 1, 36, 10'h000, NONE, NONE, 1, 1, 1, 1);

    cmd(6, 36, 8'h40); cmd(6, 17, 8'h40); cmd(0, 17); cmd(2, 17);
    expect_out("R2 tie lowest number", 1, 17, 10'h040, NONE, NONE, 1, 1, 1, 1);

    cmd(6, 36, 8'h10);
    expect_out("R2 strictly lower wins", 1, 36, 10'h010, NONE, NONE, 1, 1, 1, 1);

    cmd(4, 17);
    expect_out("R5 active min", 1, 36, 10'h010, 10'h040, 10'h040, 1, 1, 1, 1);

    group = 3'd7;
    expect_out("R5 R6 group mask", 1, 36, 10'h010, 10'h000, 10'h000, 0, 0, 1, 1);

    group = 3'd0;
    cmd(4, 36);
    expect_out("R9 two active", 1, 36, 10'h010, 10'h010, 10'h010, 0, 0, 0, 1);

    cmd(5, 36); cmd(5, 17);
    expect_out("R9 R5 none active", 1, 36, 10'h010, NONE, NONE, 1, 1, 1, 1);

    bp = 8'h20;
    expect_out("R7 basepri", 1, 36, 10'h010, NONE, 10'h020, 1, 1, 1, 1);

    fm = 1'b1;
    expect_out("R7 R6 faultmask", 1, 36, 10'h010, NONE, 10'h3FF, 1, 0, 1, 1);

    fm = 1'b0; im = 1'b1;
    expect_out("R7 R8 intmask", 1, 36, 10'h010, NONE, 10'h000, 1, 0, 1, 1);

    im = 1'b0; bp = 8'h21; group = 3'd2;
    expect_out("R7 masked basepri", 1, 36, 10'h010, NONE, 10'h020, 1, 1, 1, 1);

    bp = 8'h00; group = 3'd0;
    cmd(0, 2); cmd(2, 2);
    expect_out("R4 fixed -2", 1, 2, 10'h3FE, NONE, NONE, 1, 1, 1, 1);

    cmd(6, 2, 8'h80);
    expect_out("R4 fixed prio write ignored", 1, 2, 10'h3FE, NONE, NONE, 1, 1, 1, 1);

    cmd(4, 3);
    expect_out("R4 R5 R8 fixed -1 active masked", 1, 2, 10'h3FE, 10'h3FE, 10'h3FE, 0, 0, 1, 1);

    cmd(3, 2); cmd(5, 3); cmd(0, 0); cmd(2, 0); cmd(7, 36);
    expect_out("R4 R12 slot 0 ignored", 1, 36, 10'h010, NONE, NONE, 1, 1, 1, 1);

    cmd(3, 17); cmd(3, 36);
    expect_out("R3 R10 R12 cleared", 1, 0, NONE, NONE, NONE, 0, 0, 1, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule